// File: doc/BRIEF.md
# E1 Transmit System-Side Front-End

This block takes one channel of transmit data from the system side and turns it into a registered positive/negative pulse-rail pair, together with a line-rate bit tick, for a downstream pulse shaper. Three input formats are selectable on static configuration pins. Single-rail NRZ carries data plus a clock. Dual-rail NRZ carries two data rails plus a clock. Dual-rail RZ carries two data rails and no clock.

In single-rail mode the data is line-coded with AMI or HDB3. A four-slot delay line gives HDB3 its look-ahead. In dual-rail NRZ mode the rails pass straight through and the coder is bypassed. In dual-rail RZ mode the bit timing is recovered from the rails themselves. The OR of both rails is oversampled by the block clock, and a flywheel counter inserts empty slots between pulses. Two further pins select the active data level and the sampling edge of the supplied transmit clock.

All logic runs on one oversampling clock `clk`, nominally `OSR` times the line rate. The transmit clock and the data inputs are sampled by `clk`, and the block emits `tick_o` once per line bit slot.

Top module: `e1_tx_frontend`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `pos_o`, `neg_o` and `tick_o` are 0.
- R2: The mode pins select the format. `mode_i[1]`=1 selects dual-rail RZ. Otherwise `mode_i[0]`=1 selects dual-rail NRZ and `mode_i[0]`=0 selects single-rail NRZ. In both NRZ modes, one `tick_o` pulse follows each active edge of `tclk_i`: the rising edge when `fall_edge_i`=0 and the falling edge when it is 1. The rails change only in a cycle where `tick_o` is 1.
- R3: When `inv_i`=1, `tx_a_i` and `tx_b_i` are active low in every mode, and the block behaves as if they were inverted.
- R4: In single-rail mode with `hdb3_i`=0 (AMI), the bit sampled at tick k appears at tick k+4. A 1 becomes a pulse whose polarity alternates with the previous pulse, and a 0 gives no pulse. The first pulse after reset is positive (`pos_o`=1).
- R5: In single-rail mode with `hdb3_i`=1, every run of four zeros is replaced. It becomes 000V when an odd number of mark pulses has been sent since the last violation, and B00V otherwise. B takes the alternating polarity and V repeats the polarity of the pulse before it. The count starts at zero after reset. The same four-slot delay applies.
- R6: In dual-rail NRZ mode each active clock edge outputs `tx_a_i` on `pos_o` and `tx_b_i` on `neg_o`, with no added delay, and `hdb3_i` has no effect.
- R7: In dual-rail RZ mode a rising edge of the OR of the two rails gives one tick carrying the active rail. Edges on `tclk_i` have no effect.
- R8: In RZ mode no tick occurs before the first pulse after reset. After a pulse, each further `OSR` clock cycles without a new pulse give a tick with both rails 0.
- R9: `pos_o` and `neg_o` are never 1 together. In both dual-rail modes, a slot with both inputs active is output as no pulse.
- R10: In single-rail mode `tx_b_i` has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, OSR times line rate |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Input format select (see R2) |
| hdb3_i | input | 1 | 1 = HDB3, 0 = AMI (single-rail only) |
| inv_i | input | 1 | 1 = data inputs active low |
| fall_edge_i | input | 1 | 1 = sample on falling edge of tclk_i |
| tclk_i | input | 1 | Transmit clock from the system side |
| tx_a_i | input | 1 | Single-rail data, or positive rail |
| tx_b_i | input | 1 | Negative rail (dual-rail modes) |
| pos_o | output | 1 | Positive pulse rail, registered |
| neg_o | output | 1 | Negative pulse rail, registered |
| tick_o | output | 1 | One-cycle pulse per line bit slot |

## Verification
The HDB3 streams contain both substitution forms back to back and a run that starts straight out of reset, where the violation count is zero. A coder that counted parity at decision time instead of output time, or that mixed up B00V and 000V, would produce a wrong polarity on a V or B pulse. The inverted, falling-edge runs catch a block that samples on the wrong clock edge, which would shift or duplicate bits. In RZ mode the bench idles before the first pulse, toggles `tclk_i` throughout and leaves empty slots between pulses. A flywheel that ran free from reset, drifted, or reacted to `tclk_i` would add ticks or drop them. Slots where both rails are active check that the rails are never driven at the same time.

// File: rtl/e1_tx_frontend.sv
module e1_tx_frontend #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       hdb3_i,
  input  logic       inv_i,
  input  logic       fall_edge_i,
  input  logic       tclk_i,
  input  logic       tx_a_i,
  input  logic       tx_b_i,
  output logic       pos_o,
  output logic       neg_o,
  output logic       tick_o
);
  localparam int CW = (OSR > 2) ? $clog2(OSR) : 1;
  localparam logic [CW-1:0] CMAX = CW'(OSR - 1);
  localparam logic [1:0] SZ = 2'd0, SM = 2'd1, SV = 2'd2, SB = 2'd3;

  logic ck_q, ck_qq, a_q, b_q, or_qq;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_q <= 1'b0; ck_qq <= 1'b0; a_q <= 1'b0; b_q <= 1'b0; or_qq <= 1'b0;
    end else begin
      ck_q  <= tclk_i;
      ck_qq <= ck_q;
      a_q   <= tx_a_i ^ inv_i;
      b_q   <= tx_b_i ^ inv_i;
      or_qq <= a_q | b_q;
    end
  end

  wire rz_mode   = mode_i[1];
  wire dual_mode = !mode_i[1] && mode_i[0];
  wire sgl_mode  = !mode_i[1] && !mode_i[0];
  wire ck_edge   = fall_edge_i ? (ck_qq & ~ck_q) : (~ck_qq & ck_q);
  wire nrz_stb   = !rz_mode && ck_edge;

  // clock recovery for RZ input
  logic [CW-1:0] fw_cnt;
  logic          fw_armed;
  wire rz_pulse = rz_mode && (a_q | b_q) && !or_qq;
  wire fw_tick  = rz_mode && fw_armed && !rz_pulse && (fw_cnt == CMAX);

  always_ff @(posedge clk) begin
    if (!rst_n || !rz_mode) begin
      fw_cnt <= '0; fw_armed <= 1'b0;
    end else if (rz_pulse) begin
      fw_cnt <= '0; fw_armed <= 1'b1;
    end else if (fw_cnt == CMAX) begin
      fw_cnt <= '0;
    end else begin
      fw_cnt <= fw_cnt + 1'b1;
    end
  end

  // line coder: four-slot delay of symbol codes
  logic [1:0] dl0, dl1, dl2, dl3;
  logic [1:0] zrun;
  logic       odd_b, last_pos;
  wire out_b    = (dl3 == SM) || (dl3 == SB);
  wire odd_nx   = (dl3 == SV) ? 1'b0 : (odd_b ^ out_b);
  wire do_sub   = hdb3_i && !a_q && (zrun == 2'd3);
  wire sgl_stb  = sgl_mode && ck_edge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dl0 <= SZ; dl1 <= SZ; dl2 <= SZ; dl3 <= SZ;
      zrun <= '0; odd_b <= 1'b0; last_pos <= 1'b0;
    end else if (sgl_stb) begin
      dl3   <= (do_sub && !odd_nx) ? SB : dl2;
      dl2   <= dl1;
      dl1   <= dl0;
      dl0   <= do_sub ? SV : (a_q ? SM : SZ);
      zrun  <= (a_q || do_sub) ? 2'd0 : zrun + 2'd1;
      odd_b <= odd_nx;
      if (out_b) last_pos <= ~last_pos;
    end
  end

  logic enc_p, enc_n;
  always_comb begin
    enc_p = 1'b0; enc_n = 1'b0;
    if (out_b) begin
      enc_p = ~last_pos; enc_n = last_pos;
    end else if (dl3 == SV) begin
      enc_p = last_pos; enc_n = ~last_pos;
    end
  end

  wire dual_p = a_q & ~b_q;
  wire dual_n = b_q & ~a_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_o <= 1'b0; neg_o <= 1'b0; tick_o <= 1'b0;
    end else begin
      tick_o <= nrz_stb | rz_pulse | fw_tick;
      if (sgl_stb) begin
        pos_o <= enc_p; neg_o <= enc_n;
      end else if ((dual_mode && ck_edge) || rz_pulse) begin
        pos_o <= dual_p; neg_o <= dual_n;
      end else if (fw_tick) begin
        pos_o <= 1'b0; neg_o <= 1'b0;
      end
    end
  end

  // output-side observers for the checks below
  logic       ob_seen, ob_last_pos;
  logic [2:0] ob_zeros;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ob_seen <= 1'b0; ob_last_pos <= 1'b0; ob_zeros <= '0;
    end else if (tick_o) begin
      if (pos_o || neg_o) begin
        ob_seen <= 1'b1; ob_last_pos <= pos_o; ob_zeros <= '0;
      end else if (ob_zeros != 3'd7) begin
        ob_zeros <= ob_zeros + 3'd1;
      end
    end
  end

  p_rails_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_o && neg_o));

  p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |-> ($stable(pos_o) && $stable(neg_o)));

  p_ami_alternate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sgl_mode && !hdb3_i && tick_o && (pos_o || neg_o) && ob_seen) |-> (pos_o != ob_last_pos));

  p_hdb3_zero_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sgl_mode && hdb3_i && ob_seen) |-> (ob_zeros <= 3'd3));
endmodule

// File: tb/e1_tx_frontend_test.sv
module e1_tx_frontend_test;
  localparam int OSR = 16;
  localparam int HALF = OSR / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic hdb3 = 1'b0, inv = 1'b0, fall = 1'b0;
  logic tclk = 1'b0, txa = 1'b0, txb = 1'b0;
  logic pos, neg, tick;

  always #5 clk = ~clk;

  e1_tx_frontend #(.OSR(OSR)) uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .hdb3_i(hdb3), .inv_i(inv),
    .fall_edge_i(fall), .tclk_i(tclk), .tx_a_i(txa), .tx_b_i(txb),
    .pos_o(pos), .neg_o(neg), .tick_o(tick));

  typedef struct { logic [1:0] v; string tag; } exp_t;
  exp_t q[$];
  exp_t e;
  int checks = 0, fails = 0, ticks = 0;
  bit mon_en = 1'b0;
  int bits[64];
  int sym[64];

  always @(negedge clk) begin
    if (mon_en && rst_n && tick) begin
      ticks++;
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R7/R8 unexpected tick: rails=%b expected no tick", {pos, neg});
      end else begin
        e = q.pop_front();
        if ({pos, neg} !== e.v) begin
          fails++;
          $display("FAIL %s rails=%b expected %b", e.tag, {pos, neg}, e.v);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic logic [1:0] enc(input int s);
    return (s > 0) ? 2'b10 : ((s < 0) ? 2'b01 : 2'b00);
  endfunction

  task automatic push(input logic [1:0] v, input string tag);
    exp_t x;
    x.v = v; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // line code model over bits[0..n-1]
  task automatic model(input int n, input bit use_hdb3);
    int last = -1, odd = 0, zeros = 0;
    for (int i = 0; i < n; i++) begin
      sym[i] = 0;
      if (bits[i] != 0) begin
        last = -last; sym[i] = last; odd ^= 1; zeros = 0;
      end else begin
        zeros++;
        if (use_hdb3 && zeros == 4) begin
          if (odd == 0) begin
            last = -last; sym[i-3] = last;
          end
          sym[i] = last; odd = 0; zeros = 0;
        end
      end
    end
  endtask

  task automatic configure(input logic [1:0] m, input logic h, input logic iv, input logic f);
    mon_en = 1'b0;
    q.delete();
    rst_n = 1'b0;
    mode = m; hdb3 = h; inv = iv; fall = f;
    tclk = ~f ? 1'b0 : 1'b1;
    txa = iv; txb = iv;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    mon_en = 1'b1;
  endtask

  task automatic send_nrz(input logic a, input logic b);
    logic act;
    act = ~fall;
    tclk = ~act; txa = a ^ inv; txb = b ^ inv;
    repeat (HALF) @(negedge clk);
    tclk = act;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_rz(input int s);
    txa = ((s == 1) || (s == 2)) ^ inv;
    txb = ((s == -1) || (s == 2)) ^ inv;
    for (int k = 0; k < HALF; k++) begin
      if (k % 3 == 0) tclk = ~tclk;
      @(negedge clk);
    end
    txa = inv; txb = inv;
    for (int k = 0; k < HALF; k++) begin
      if (k % 3 == 1) tclk = ~tclk;
      @(negedge clk);
    end
  endtask

  task automatic drain(input string tag);
    int k;
    k = 0;
    while (k < 200 && q.size() != 0) begin
      @(negedge clk);
      k++;
    end
    check(tag, q.size(), 0);
    mon_en = 1'b0;
  endtask

  task automatic run_single(input logic [31:0] pat, input int n, input string tag);
    for (int i = 0; i < n; i++) bits[i] = pat[n-1-i] ? 1 : 0;
    for (int i = n; i < n + 4; i++) bits[i] = 0;
    model(n + 4, hdb3);
    for (int i = 0; i < 4; i++) push(2'b00, tag);
    for (int i = 0; i < n; i++) push(enc(sym[i]), tag);
    for (int i = 0; i < n + 4; i++) send_nrz(bits[i] != 0, (i % 3) == 0); // R10: tx_b toggles
    drain(tag);
  endtask

  initial begin
    // R1: reset state
    configure(2'b00, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 tick in reset", tick, 0);
    check("R1 rails in reset", {pos, neg}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rails after reset", {pos, neg, tick}, 0);

    // R4, R10: AMI, rising edge, tx_b noise
    configure(2'b00, 1'b0, 1'b0, 1'b0);
    run_single(32'b1101_0000_1101_0011, 16, "R4 AMI");

    // R5: HDB3 with both substitution forms
    configure(2'b00, 1'b1, 1'b0, 1'b0);
    run_single(32'b1_0000_0000_1_1_0000_1_0000_0_1, 22, "R5 HDB3");

    // R2, R3, R5: falling edge, inverted data, zeros straight from reset
    configure(2'b00, 1'b1, 1'b1, 1'b1);
    run_single(32'b0000_1000_0000_1011_00, 18, "R2/R3 HDB3 falling inverted");

    // R6, R9: dual-rail NRZ, hdb3 set but bypassed
    configure(2'b01, 1'b1, 1'b0, 1'b0);
    begin
      int pa[10] = '{1, 0, 0, 0, 0, 0, 1, 0, 1, 0};
      int pb[10] = '{0, 1, 0, 0, 0, 0, 1, 1, 0, 0};
      for (int i = 0; i < 10; i++) begin
        if (pa[i] != 0 && pb[i] != 0) push(2'b00, "R9 dual both active");
        else push({pa[i] != 0, pb[i] != 0}, "R6 dual NRZ");
      end
      for (int i = 0; i < 10; i++) send_nrz(pa[i] != 0, pb[i] != 0);
    end
    drain("R6 dual NRZ drain");

    // R2, R3, R6: dual-rail NRZ, falling edge, inverted
    configure(2'b01, 1'b0, 1'b1, 1'b1);
    push(2'b01, "R3 dual inverted"); push(2'b10, "R3 dual inverted");
    push(2'b00, "R2 dual falling"); push(2'b00, "R9 dual inverted both");
    send_nrz(1'b0, 1'b1); send_nrz(1'b1, 1'b0); send_nrz(1'b0, 1'b0); send_nrz(1'b1, 1'b1);
    drain("R2 dual falling drain");

    // R7, R8, R9: RZ, tclk toggling, idle before first pulse
    configure(2'b10, 1'b1, 1'b0, 1'b0);
    ticks = 0;
    for (int i = 0; i < 3; i++) send_rz(0);
    check("R8 no tick before first pulse", ticks, 0);
    begin
      int sl[10] = '{1, 0, -1, 0, 0, 1, 2, -1, 0, 0};
      for (int i = 0; i < 10; i++)
        push(enc(sl[i] == 2 ? 0 : sl[i]), (sl[i] == 0) ? "R8 flywheel slot" : "R7 RZ pulse");
      for (int i = 0; i < 8; i++) send_rz(sl[i]);
    end
    drain("R8 RZ drain");

    // R3, R7: RZ with active-low rails
    configure(2'b10, 1'b0, 1'b1, 1'b0);
    push(2'b01, "R3 RZ inverted"); push(2'b00, "R8 flywheel inverted");
    push(2'b10, "R3 RZ inverted");
    send_rz(-1); send_rz(0); send_rz(1);
    drain("R3 RZ drain");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule